// File: doc/BRIEF.md
# Segmented Audio DAC Code Splitter with First-Order Noise Shaper

This block takes signed audio samples and produces the digital drive for a hybrid converter. The analog side of that converter has three parts: a binary-weighted ladder driven by a coarse code, one switched current that restores a fixed offset weight, and a one-bit current source weighted like the ladder LSB. The block registers each new sample when a valid strobe arrives. It applies a sign-dependent digital offset so that the coarse ladder never switches its major carry at the zero crossing. It then splits the corrected word into a coarse ladder code and a fine remainder. The fine remainder is turned into a one-bit stream by a first-order accumulator that runs on every system clock.

For a non-negative sample, the weight of bit position `OFS_BIT` is taken out of the word and the offset-enable output is raised, so the analog side adds that weight back. For a negative sample, nothing is removed and the offset switch stays off. The corrected word is offset-binary. Over time, the sum of the ladder weight, the fine bits and the offset weight equals the sample plus half of full scale. The system clock is expected to run at an integer multiple of the word rate, giving 2x to 16x oversampling of the one-bit path. The offset position is fixed when the block is built. Bit 9 and bit 4 are the two intended settings.

Top module: `seg_dac_splitter`

## Requirements
- R1: After a strobed sample s, the value ladder_code*256 + fine + ofs_en*2^OFS_BIT equals s + 2^17. Here fine is the low 8 bits of the corrected word and ladder_code is its upper 10 bits.
- R2: After a strobed sample, ofs_en is 1 when the sample's sign bit (bit 17) is 0 and 0 when that bit is 1.
- R3: The most negative sample (0x20000) gives ladder_code 0 and ofs_en 0. The most positive sample (0x1FFFF) gives ladder_code (2^18-1-2^OFS_BIT)>>8.
- R4: ladder_code and ofs_en change only in the cycle after a clock edge where smp_vld is high. When smp_vld is low, changes on smp_in have no effect.
- R5: On every clock edge out of reset, an 8-bit accumulator adds the fine bits of the last latched word, and ns_bit is the carry of that addition. While one word is held, any 256 consecutive ns_bit values contain exactly fine ones.
- R6: The accumulator is not cleared when a new sample is latched. Its state carries across sample boundaries.
- R7: A synchronous high rst clears the accumulator and ns_bit to 0. It sets ladder_code, ofs_en and fine to the values for a zero sample: ladder_code (2^17-2^OFS_BIT)>>8 and ofs_en 1.
- R8: The same rules hold for OFS_BIT = 9 and OFS_BIT = 4. For OFS_BIT = 4 the offset falls inside the fine bits.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (noise-shaper rate) |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Marks a new sample on smp_in |
| smp_in | input | 18 | Two's-complement audio sample |
| ladder_code | output | 10 | Registered coarse ladder code |
| ofs_en | output | 1 | Registered offset-current enable |
| ns_bit | output | 1 | Noise-shaped one-bit output |

## Verification
The collision that matters is a sample strobe arriving on the same edge as an accumulator step. On that edge the shaper must still add the fine bits of the outgoing word, while the coarse code and offset switch to the incoming word, and the accumulator residue must survive into the next word. The sweep strobes new words on every cycle and on every third cycle, so carries and strobes coincide often. A bench model of the accumulator that follows the same edge ordering judges each cycle's ns_bit, ladder_code and ofs_en. Held-word windows of 256 cycles then count the ones against the fine value, using two instances with offsets at bit 9 and bit 4.

// File: rtl/seg_dac_splitter.sv
module seg_dac_splitter #(
  parameter int W       = 18,
  parameter int LW      = 10,
  parameter int OFS_BIT = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_vld,
  input  logic [W-1:0]  smp_in,
  output logic [LW-1:0] ladder_code,
  output logic          ofs_en,
  output logic          ns_bit
);
  localparam int FW = W - LW;
  localparam logic [W-1:0] MID    = W'(1) << (W - 1);
  localparam logic [W-1:0] OFS_WT = W'(1) << OFS_BIT;
  localparam logic [W-1:0] ZERO_U = MID - OFS_WT;

  logic [FW-1:0] fine_q;
  logic [FW-1:0] acc_q;
  logic          nonneg;
  logic [W-1:0]  ucode;
  logic [FW:0]   acc_sum;

  assign nonneg  = ~smp_in[W-1];
  assign ucode   = smp_in + MID - (nonneg ? OFS_WT : '0);
  assign acc_sum = {1'b0, acc_q} + {1'b0, fine_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ladder_code <= ZERO_U[W-1:FW];
      fine_q      <= ZERO_U[FW-1:0];
      ofs_en      <= 1'b1;
      acc_q       <= '0;
      ns_bit      <= 1'b0;
    end else begin
      acc_q  <= acc_sum[FW-1:0];
      ns_bit <= acc_sum[FW];
      if (smp_vld) begin
        ladder_code <= ucode[W-1:FW];
        fine_q      <= ucode[FW-1:0];
        ofs_en      <= nonneg;
      end
    end
  end
endmodule

// File: rtl/seg_dac_splitter_chk.sv
module seg_dac_splitter_chk #(
  parameter int W       = 18,
  parameter int LW      = 10,
  parameter int OFS_BIT = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_vld,
  input logic [W-1:0]  smp_in,
  input logic [LW-1:0] ladder_code,
  input logic          ofs_en,
  input logic          ns_bit,
  input logic [W-LW-1:0] fine_q
);
  localparam int FW = W - LW;
  localparam logic [W-1:0] MID    = W'(1) << (W - 1);
  localparam logic [W-1:0] OFS_WT = W'(1) << OFS_BIT;
  localparam logic [W-1:0] ZERO_U = MID - OFS_WT;
  localparam logic [W-1:0] MINV   = W'(1) << (W - 1);

  logic [W-1:0] rebuilt;
  logic [W-1:0] target;
  assign rebuilt = {ladder_code, fine_q} + (ofs_en ? OFS_WT : '0);
  assign target  = smp_in + MID;

  p_rebuild_r1: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> rebuilt == $past(target));
  p_offset_sign_r2: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> ofs_en == !$past(smp_in[W-1]));
  p_min_code_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && smp_in == MINV) |=> (ladder_code == '0 && !ofs_en));
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> ($stable(ladder_code) && $stable(ofs_en)));
  p_reset_r7: assert property (@(posedge clk)
    rst |=> (ladder_code == ZERO_U[W-1:FW] && ofs_en && !ns_bit));
endmodule

bind seg_dac_splitter seg_dac_splitter_chk #(.W(W), .LW(LW), .OFS_BIT(OFS_BIT)) u_chk (
  .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_in),
  .ladder_code(ladder_code), .ofs_en(ofs_en), .ns_bit(ns_bit), .fine_q(fine_q)
);

// File: tb/sim_seg_dac_splitter.sv
module sim_seg_dac_splitter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic [17:0] smp_in = '0;
  logic [9:0] lad0, lad1;
  logic ofs0, ofs1, ns0, ns1;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seg_dac_splitter u0 (.clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_in),
    .ladder_code(lad0), .ofs_en(ofs0), .ns_bit(ns0));
  seg_dac_splitter #(.OFS_BIT(4)) u1 (.clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_in),
    .ladder_code(lad1), .ofs_en(ofs1), .ns_bit(ns1));

  function automatic int corr(input logic [17:0] s, input int n);
    int v;
    v = $signed(s);
    return v + 131072 - ((v >= 0) ? (1 << n) : 0);
  endfunction

  int m_acc[2], m_fine[2], m_lad[2], m_ofs[2], m_bit[2];
  localparam int NB[2] = '{9, 4};

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        m_acc[k]  <= 0;
        m_bit[k]  <= 0;
        m_lad[k]  <= (131072 - (1 << NB[k])) >> 8;
        m_fine[k] <= (131072 - (1 << NB[k])) & 255;
        m_ofs[k]  <= 1;
      end else begin
        m_acc[k] <= (m_acc[k] + m_fine[k]) & 255;
        m_bit[k] <= (m_acc[k] + m_fine[k]) >> 8;
        if (smp_vld) begin
          m_lad[k]  <= corr(smp_in, NB[k]) >> 8;
          m_fine[k] <= corr(smp_in, NB[k]) & 255;
          m_ofs[k]  <= ($signed(smp_in) >= 0) ? 1 : 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string ctx);
    chk({ctx, " R1 ladder n9"}, lad0, m_lad[0]);
    chk({ctx, " R8 ladder n4"}, lad1, m_lad[1]);
    chk({ctx, " R2 offset n9"}, ofs0, m_ofs[0]);
    chk({ctx, " R8 offset n4"}, ofs1, m_ofs[1]);
    chk({ctx, " R5 R6 bit n9"}, ns0, m_bit[0]);
    chk({ctx, " R5 R6 bit n4"}, ns1, m_bit[1]);
  endtask

  task automatic step(input bit v, input logic [17:0] s, input string ctx);
    @(negedge clk);
    check_all(ctx);
    smp_vld = v;
    smp_in  = s;
  endtask

  initial begin
    logic [17:0] corners[10];
    corners = '{18'h00000, 18'h00001, 18'h3FFFF, 18'h1FFFF, 18'h20000,
                18'h00200, 18'h001FF, 18'h00010, 18'h3FE00, 18'h000FF};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset ladder n9", lad0, (131072 - 512) >> 8);
    chk("R7 reset ladder n4", lad1, (131072 - 16) >> 8);
    chk("R7 reset offset", ofs0 & ofs1, 1);
    chk("R7 reset bit", ns0 | ns1, 0);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) begin
      step(1'b1, corners[i], "corner");
      step(1'b0, ~corners[i], "corner hold R4");
      step(1'b0, 18'h15555, "corner hold R4");
      step(1'b0, 18'h2AAAA, "corner hold R4");
      if (corners[i] == 18'h20000) begin
        chk("R3 min ladder", lad0 | lad1, 0);
        chk("R3 min offset", ofs0 | ofs1, 0);
      end
      if (corners[i] == 18'h1FFFF) begin
        chk("R3 max ladder n9", lad0, (262143 - 512) >> 8);
        chk("R3 max ladder n4", lad1, (262143 - 16) >> 8);
      end
    end
    for (int i = 0; i < 8192; i++) begin
      logic [17:0] s;
      s = 18'(i * 32 + (i % 32) + ((i & 1) ? 18'h20000 : 0));
      if (i < 4096) step(1'b1, s, "sweep strobe every cycle");
      else begin
        step(1'b1, s, "sweep strobe every 3rd");
        step(1'b0, 18'(s + 7), "sweep hold R4");
        step(1'b0, 18'(~s), "sweep hold R4");
      end
    end
    for (int t = 0; t < 6; t++) begin
      logic [17:0] s;
      int ones0, ones1, f0, f1;
      s = 18'(t * 43691 + 5);
      f0 = corr(s, 9) & 255;
      f1 = corr(s, 4) & 255;
      step(1'b1, s, "window");
      step(1'b0, 18'h3F0F0, "window hold R4");
      ones0 = 0; ones1 = 0;
      for (int c = 0; c < 256; c++) begin
        @(negedge clk);
        check_all("window");
        ones0 += ns0;
        ones1 += ns1;
        smp_in = 18'(c * 977);
        if (c == 255) begin
          @(posedge clk);
        end
      end
      chk("R5 ones in 256 cycles n9", ones0, f0);
      chk("R5 R8 ones in 256 cycles n4", ones1, f1);
    end
    step(1'b0, '0, "final");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule